// File: doc/BRIEF.md
# Masked GPIO Port with Level Alarms

This block is a general-purpose I/O port of up to 32 bits, controlled through a single-cycle command port. Software names an operation and a bit mask in one cycle. The port then sets or clears output bits, turns bits into inputs or outputs, reads back the synchronised pins, the output shadow or the direction, and arms or disarms a per-bit level alarm. Each alarm watches for either a high level or a low level on its pin. A registered level interrupt stays high while any armed condition holds, so it can wake a sleeping processor.

Each pin drives an output value and an output enable to an external pad. A bit that is switched to input keeps its output value in the shadow register, and that value reappears when the bit is switched back to output. Input pins pass through two flops before they are read or compared against the alarms.

A small sequencer with two states accepts the commands. ST_IDLE means no response is pending, and ST_RESP means a response is on the response port this cycle. The transitions are ACCEPT (ST_IDLE to ST_RESP on a valid command), CHAIN (ST_RESP to ST_RESP when another command arrives right away) and DRAIN (ST_RESP to ST_IDLE when no command arrives). With no command in ST_IDLE the sequencer stays in ST_IDLE.

Top module: `gpio_alarm_port`

## Requirements
- R1: After reset, `gpio_oe` is 0 (all bits are inputs), `gpio_out` is 0, every alarm is disarmed, `irq` is 0 and `rsp_valid` is 0.
- R2: Op code 2 (set) drives `gpio_out` high on every bit whose mask bit is 1. All other bits keep their value. The change is visible after the edge that accepts the command.
- R3: Op code 3 (clear) drives `gpio_out` low on every bit whose mask bit is 1. All other bits keep their value.
- R4: Op code 4 (make input) clears the direction bit of every masked bit (0 = input). Unmasked bits keep their direction. The response carries the synchronised input pins.
- R5: Op code 5 (make output) sets the direction bit of every masked bit (1 = output). Unmasked bits keep their direction. The response carries the output shadow.
- R6: `gpio_out` always carries the output shadow, whatever the direction, and `gpio_oe` equals the direction register. Set and clear update the shadow of input bits too, so the value is kept for a later switch to output.
- R7: The read ops return values with no side effect. Op 0 returns the synchronised pins, op 1 the output shadow, and op 9 the direction register. A pin change reaches op 0 only when the command is accepted on the third rising edge after the change or later.
- R8: Op 6 arms a high-level alarm and op 7 arms a low-level alarm on each masked bit. Arming one condition disarms the other on that bit. Op 10 reads the high-armed bits and op 11 the low-armed bits.
- R9: Op 8 disarms both alarm conditions on each masked bit and leaves the other bits armed.
- R10: `irq` is a register holding the OR over all bits of (high-armed AND pin high) OR (low-armed AND pin low), taken on the synchronised pins. After a pin change it rises on the third rising edge. After an arming or disarming command it changes one edge after the accepting edge.
- R11: `rsp_valid` is high in exactly the cycle after each accepted command, including back-to-back commands. Op codes 12 to 15 change no state and return 0. Set, clear, arm and disarm also return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 4 | Operation code |
| cmd_mask | input | WIDTH | Per-bit mask for the operation |
| rsp_valid | output | 1 | Response data is valid |
| rsp_data | output | WIDTH | Response data |
| gpio_in | input | WIDTH | Raw input pins |
| gpio_out | output | WIDTH | Output shadow driven to the pads |
| gpio_oe | output | WIDTH | Output enable per bit (1 = drive) |
| irq | output | 1 | Level alarm interrupt |

## Verification
A corrupted shadow or direction bit shows up on `gpio_out` or `gpio_oe` in the cycle after the accepting edge, and it stays there until a command rewrites that bit. A wrong alarm bit stays out of sight until its pin takes the armed level. It then shows on `irq` one edge later, or on the op 10 and op 11 readbacks one cycle after the command. A fault in the synchroniser depth or the sequencer moves the response or the interrupt by a whole cycle. Back-to-back reads across a pin change and the interrupt timing checks expose that shift.

// File: rtl/gpio_alarm_pkg.sv
package gpio_alarm_pkg;

    typedef enum logic [3:0] {
        OP_RD_IN    = 4'd0,
        OP_RD_OUT   = 4'd1,
        OP_SET      = 4'd2,
        OP_CLR      = 4'd3,
        OP_TO_IN    = 4'd4,
        OP_TO_OUT   = 4'd5,
        OP_ARM_HI   = 4'd6,
        OP_ARM_LO   = 4'd7,
        OP_DISARM   = 4'd8,
        OP_RD_DIR   = 4'd9,
        OP_RD_ARMHI = 4'd10,
        OP_RD_ARMLO = 4'd11
    } gpio_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } seq_state_e;

    // one-hot write strobes shared by every bit cell
    typedef struct packed {
        logic set_b;
        logic clr_b;
        logic to_in;
        logic to_out;
        logic arm_hi;
        logic arm_lo;
        logic disarm;
    } bit_cmd_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) stage_q[s] <= raw_in;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[LAST];
endmodule

// File: rtl/gpio_bit_cell.sv
module gpio_bit_cell
    import gpio_alarm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bit_cmd_t cmd,
    input  logic     sel,
    input  logic     pin,
    output logic     shadow,
    output logic     dir,
    output logic     arm_hi,
    output logic     arm_lo,
    output logic     hit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= 1'b0;
            dir    <= 1'b0;
            arm_hi <= 1'b0;
            arm_lo <= 1'b0;
        end else if (sel) begin
            if (cmd.set_b)  shadow <= 1'b1;
            if (cmd.clr_b)  shadow <= 1'b0;
            if (cmd.to_in)  dir    <= 1'b0;
            if (cmd.to_out) dir    <= 1'b1;
            if (cmd.arm_hi) begin
                arm_hi <= 1'b1;
                arm_lo <= 1'b0;
            end
            if (cmd.arm_lo) begin
                arm_hi <= 1'b0;
                arm_lo <= 1'b1;
            end
            if (cmd.disarm) begin
                arm_hi <= 1'b0;
                arm_lo <= 1'b0;
            end
        end
    end

    assign hit = (arm_hi & pin) | (arm_lo & ~pin);
endmodule

// File: rtl/gpio_cmd_seq.sv
module gpio_cmd_seq
    import gpio_alarm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] shadow_v,
    input  logic [WIDTH-1:0] dir_v,
    input  logic [WIDTH-1:0] arm_hi_v,
    input  logic [WIDTH-1:0] arm_lo_v,
    output bit_cmd_t         strobe,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data
);
    seq_state_e       state_q, state_d;
    logic [WIDTH-1:0] rd_value;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ACCEPT / CHAIN / DRAIN
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = cmd_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = cmd_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // command decode
    always_comb begin
        strobe   = '0;
        rd_value = '0;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_RD_IN:    rd_value = pins_sync;
                OP_RD_OUT:   rd_value = shadow_v;
                OP_SET:      strobe.set_b = 1'b1;
                OP_CLR:      strobe.clr_b = 1'b1;
                OP_TO_IN: begin
                    strobe.to_in = 1'b1;
                    rd_value     = pins_sync;
                end
                OP_TO_OUT: begin
                    strobe.to_out = 1'b1;
                    rd_value      = shadow_v;
                end
                OP_ARM_HI:   strobe.arm_hi = 1'b1;
                OP_ARM_LO:   strobe.arm_lo = 1'b1;
                OP_DISARM:   strobe.disarm = 1'b1;
                OP_RD_DIR:   rd_value = dir_v;
                OP_RD_ARMHI: rd_value = arm_hi_v;
                OP_RD_ARMLO: rd_value = arm_lo_v;
                default:     rd_value = '0;
            endcase
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rsp_data <= '0;
        else if (cmd_valid) rsp_data <= rd_value;
    end

    assign rsp_valid = (state_q == ST_RESP);
endmodule

// File: rtl/gpio_alarm_port.sv
module gpio_alarm_port
    import gpio_alarm_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [3:0]       cmd_op,
    input  logic [WIDTH-1:0] cmd_mask,
    output logic             rsp_valid,
    output logic [WIDTH-1:0] rsp_data,
    input  logic [WIDTH-1:0] gpio_in,
    output logic [WIDTH-1:0] gpio_out,
    output logic [WIDTH-1:0] gpio_oe,
    output logic             irq
);
    localparam int SYNC_STAGES = 2;

    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] shadow_v, dir_v, arm_hi_v, arm_lo_v, hit_v;
    bit_cmd_t         strobe;
    logic             irq_q;

    gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (gpio_in),
        .sync_out (pins_sync)
    );

    gpio_cmd_seq #(.WIDTH(WIDTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .pins_sync (pins_sync),
        .shadow_v  (shadow_v),
        .dir_v     (dir_v),
        .arm_hi_v  (arm_hi_v),
        .arm_lo_v  (arm_lo_v),
        .strobe    (strobe),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            gpio_bit_cell u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .cmd    (strobe),
                .sel    (cmd_mask[b]),
                .pin    (pins_sync[b]),
                .shadow (shadow_v[b]),
                .dir    (dir_v[b]),
                .arm_hi (arm_hi_v[b]),
                .arm_lo (arm_lo_v[b]),
                .hit    (hit_v[b])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |hit_v;
    end

    assign gpio_out = shadow_v;
    assign gpio_oe  = dir_v;
    assign irq      = irq_q;
endmodule

// File: rtl/gpio_alarm_port_chk.sv
module gpio_alarm_port_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [3:0]       cmd_op,
    input logic [WIDTH-1:0] cmd_mask,
    input logic             rsp_valid,
    input logic [WIDTH-1:0] gpio_out,
    input logic [WIDTH-1:0] gpio_oe,
    input logic             irq,
    input logic [WIDTH-1:0] arm_hi,
    input logic [WIDTH-1:0] arm_lo
);
    assert_set_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd2) |=> ((gpio_out & $past(cmd_mask)) == $past(cmd_mask)));

    assert_clr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd3) |=> ((gpio_out & $past(cmd_mask)) == '0));

    assert_oe_by_dir_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_oe) |-> $past(cmd_valid && (cmd_op == 4'd4 || cmd_op == 4'd5)));

    assert_to_out_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 4'd5) |=> ((gpio_oe & $past(cmd_mask)) == $past(cmd_mask)));

    assert_out_by_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_out) |-> $past(cmd_valid && (cmd_op == 4'd2 || cmd_op == 4'd3)));

    assert_arm_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_hi & arm_lo) == '0);

    assert_irq_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(|(arm_hi | arm_lo)));

    assert_rsp_follows_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(cmd_valid));
endmodule

bind gpio_alarm_port gpio_alarm_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_mask  (cmd_mask),
    .rsp_valid (rsp_valid),
    .gpio_out  (gpio_out),
    .gpio_oe   (gpio_oe),
    .irq       (irq),
    .arm_hi    (arm_hi_v),
    .arm_lo    (arm_lo_v)
);

// File: tb/gpio_alarm_port_bench.sv
module gpio_alarm_port_bench;
    localparam int W = 32;
    localparam int NV = 22;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [3:0]   cmd_op = '0;
    logic [W-1:0] cmd_mask = '0;
    logic         rsp_valid;
    logic [W-1:0] rsp_data;
    logic [W-1:0] gpio_in = '0;
    logic [W-1:0] gpio_out;
    logic [W-1:0] gpio_oe;
    logic         irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gpio_alarm_port #(.WIDTH(W)) u_gpio_alarm_port (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_mask(cmd_mask), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq(irq)
    );

    // {op, mask, pins, expected rsp, expected out, expected oe}
    localparam logic [163:0] VECS [NV] = '{
        {4'h2, 32'h000000F0, 32'h00000000, 32'h00000000, 32'h000000F0, 32'h00000000},
        {4'h5, 32'h00000030, 32'h00000000, 32'h000000F0, 32'h000000F0, 32'h00000030},
        {4'h3, 32'h00000090, 32'h00000000, 32'h00000000, 32'h00000060, 32'h00000030},
        {4'h4, 32'h00000010, 32'h0000A5A5, 32'h0000A5A5, 32'h00000060, 32'h00000020},
        {4'h0, 32'h00000000, 32'h12345678, 32'h12345678, 32'h00000060, 32'h00000020},
        {4'h1, 32'h00000000, 32'h12345678, 32'h00000060, 32'h00000060, 32'h00000020},
        {4'h9, 32'h00000000, 32'h12345678, 32'h00000020, 32'h00000060, 32'h00000020},
        {4'h2, 32'hFFFF0000, 32'h00000000, 32'h00000000, 32'hFFFF0060, 32'h00000020},
        {4'h5, 32'hFFFFFFFF, 32'h00000000, 32'hFFFF0060, 32'hFFFF0060, 32'hFFFFFFFF},
        {4'h4, 32'h0F0F0F0F, 32'hDEADBEEF, 32'hDEADBEEF, 32'hFFFF0060, 32'hF0F0F0F0},
        {4'hD, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'hFFFF0060, 32'hF0F0F0F0},
        {4'h3, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'h1, 32'h00000000, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'h6, 32'h0000000F, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'hA, 32'h00000000, 32'h00000000, 32'h0000000F, 32'h00000000, 32'hF0F0F0F0},
        {4'h7, 32'h00000003, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'hA, 32'h00000000, 32'h00000000, 32'h0000000C, 32'h00000000, 32'hF0F0F0F0},
        {4'hB, 32'h00000000, 32'h00000000, 32'h00000003, 32'h00000000, 32'hF0F0F0F0},
        {4'h8, 32'h00000001, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'hB, 32'h00000000, 32'h00000000, 32'h00000002, 32'h00000000, 32'hF0F0F0F0},
        {4'hF, 32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h00000000, 32'hF0F0F0F0},
        {4'hB, 32'h00000000, 32'h00000000, 32'h00000002, 32'h00000000, 32'hF0F0F0F0}
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the falling edge after the accepting edge
    task automatic issue(input logic [3:0] op, input logic [W-1:0] mask);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_mask  = mask;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_mask  = '0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 out", gpio_out, '0);
        chk("R1 oe", gpio_oe, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table: R2 R3 R4 R5 R6 R7 R8 R9 R11
        for (int i = 0; i < NV; i++) begin
            gpio_in = VECS[i][127:96];
            repeat (3) @(negedge clk);
            issue(VECS[i][163:160], VECS[i][159:128]);
            chk($sformatf("R11 rsp_valid v%0d", i), {31'd0, rsp_valid}, 32'd1);
            chk($sformatf("R7_R8 rsp v%0d", i), rsp_data, VECS[i][95:64]);
            chk($sformatf("R2_R3_R6 out v%0d", i), gpio_out, VECS[i][63:32]);
            chk($sformatf("R4_R5 oe v%0d", i), gpio_oe, VECS[i][31:0]);
        end
        @(negedge clk);
        chk("R11 rsp_valid drops", {31'd0, rsp_valid}, '0);

        // R7 and R11: back-to-back reads across a pin change
        gpio_in = 32'h11;
        repeat (3) @(negedge clk);
        gpio_in   = 32'h22;
        cmd_valid = 1'b1;
        cmd_op    = 4'h0;
        @(negedge clk);
        chk("R7 first read old", rsp_data, 32'h11);
        @(negedge clk);
        chk("R7 second read old", rsp_data, 32'h11);
        chk("R11 chained valid", {31'd0, rsp_valid}, 32'd1);
        @(negedge clk);
        chk("R7 third read new", rsp_data, 32'h22);
        cmd_valid = 1'b0;
        @(negedge clk);
        chk("R11 idle after chain", {31'd0, rsp_valid}, '0);

        // R10: interrupt timing
        gpio_in = '0;
        issue(4'h8, 32'hFFFFFFFF);
        repeat (3) @(negedge clk);
        chk("R10 irq clear after disarm", {31'd0, irq}, '0);
        issue(4'h6, 32'h10);
        @(negedge clk);
        chk("R10 irq low with pin low", {31'd0, irq}, '0);
        gpio_in = 32'h10;
        @(negedge clk);
        @(negedge clk);
        chk("R10 irq not yet after two edges", {31'd0, irq}, '0);
        @(negedge clk);
        chk("R10 irq on third edge", {31'd0, irq}, 32'd1);
        // R9: disarm removes the condition one edge later
        issue(4'h8, 32'h10);
        chk("R9 irq still high at accept", {31'd0, irq}, 32'd1);
        @(negedge clk);
        chk("R9 irq low after disarm", {31'd0, irq}, '0);
        // R8: low alarm, then replaced by high alarm
        issue(4'h7, 32'h100);
        @(negedge clk);
        chk("R8 low alarm fires", {31'd0, irq}, 32'd1);
        issue(4'h6, 32'h100);
        @(negedge clk);
        chk("R8 high replaces low irq", {31'd0, irq}, '0);
        issue(4'hB, '0);
        chk("R8 low arm cleared", rsp_data, '0);
        issue(4'hA, '0);
        chk("R8 high arm set", rsp_data, 32'h100);

        // R1: reset mid-run
        issue(4'h5, 32'hFF);
        issue(4'h2, 32'hFF);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 out after reset", gpio_out, '0);
        chk("R1 oe after reset", gpio_oe, '0);
        chk("R1 irq after reset", {31'd0, irq}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(4'hA, '0);
        chk("R1 arms cleared", rsp_data, '0);

        finish_run();
    end
endmodule